// File: doc/BRIEF.md
# Phase Detector with Hysteretic Lock Indicator

This block sits after the reference and feedback dividers of a frequency synthesizer. It runs on the reference-oscillator clock and receives two single-cycle pulses: `fr_in` from the reference divider and `fp_in` from the feedback divider. It measures, in oscillator clocks, how far one pulse leads the other. For that many cycles it drives one of two charge-pump controls. After every comparison it asserts both controls for one clock, so that small errors still produce drive and there is no dead zone. `pump_oe` is high whenever either control is active. When it is low, the charge-pump node is floating (high impedance).

A polarity input chooses which control answers a leading reference. This lets the loop match a voltage-controlled oscillator whose tuning slope is either positive or negative. The lock flag drops as soon as one comparison shows a gap of three or more clocks. It rises again only after three consecutive comparisons with a gap of at most two clocks. A monitor output shows either the lock flag or one of the two divider pulses.

When the power input is low, the outputs go quiet, the lock flag is forced high and incoming pulses are ignored. The first comparison after power returns produces no drive and is not counted by the lock detector. This keeps a stale phase relationship from kicking the oscillator.

Top module: `pd_lockdet`

## Requirements
- R1: While reset is asserted and just after it, with `pwr_on`=1, the outputs `pump_up`, `pump_dn`, `pump_oe` and `lock_flag` are all 0.
- R2: With `pol_fc`=1, suppose an `fr_in` pulse arrives in cycle t and the next `fp_in` pulse arrives in cycle t+e, with e>0. Then `pump_up`=1 and `pump_dn`=0 in cycles t+1 through t+e.
- R3: With `pol_fc`=1, when `fp_in` leads `fr_in` by e clocks, `pump_dn`=1 and `pump_up`=0 in cycles t+1 through t+e.
- R4: With `pol_fc`=0, the roles of the two controls are exchanged: a leading `fr_in` drives `pump_dn` and a leading `fp_in` drives `pump_up`.
- R5: When both pulses arrive in the same cycle t, the only activity is a single cycle, t+1, in which both controls are high.
- R6: Every comparison ends with exactly one cycle in which `pump_up`, `pump_dn` and `pump_oe` are all 1. In the cycle after that, all three are 0 unless a new pulse has arrived. `pump_oe` is 1 exactly when at least one control is 1.
- R7: A comparison whose gap is 3 or more clocks clears `lock_flag`, starting in the cycle after the completing pulse.
- R8: `lock_flag` is set only after three consecutive comparisons with a gap of 2 or fewer clocks. A comparison with a larger gap restarts the count. The flag becomes visible in the cycle after the third completing pulse.
- R9: While `pwr_on`=0, all pump outputs are 0 and `lock_flag`=1, and incoming pulses cause no pump activity.
- R10: After `pwr_on` returns to 1, the first comparison produces no pump activity and does not change `lock_flag`. The comparison after it behaves normally.
- R11: With `mon_sel`=1, `mon_out` follows `fr_in` when `pol_fc`=1 and follows `fp_in` when `pol_fc`=0. With `mon_sel`=0, `mon_out` follows `lock_flag`.
- R12: Once a lead has started, a further pulse from the leading divider does not restart the measurement. The lead output stays on until the lagging pulse arrives, and the gap is counted from the first pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_in | input | 1 | Single-cycle pulse from the reference divider |
| fp_in | input | 1 | Single-cycle pulse from the feedback divider |
| pwr_on | input | 1 | 1 = normal operation, 0 = power save |
| pol_fc | input | 1 | Pump polarity select |
| mon_sel | input | 1 | 1 = monitor shows a divider pulse, 0 = monitor shows the lock flag |
| pump_up | output | 1 | Drive the charge-pump output high |
| pump_dn | output | 1 | Drive the charge-pump output low |
| pump_oe | output | 1 | Charge-pump output enabled (0 = high impedance) |
| lock_flag | output | 1 | Lock indicator |
| mon_out | output | 1 | Monitor output |

## Verification
The hardest case to reach is the restart after power save. The suppression flag is set only during power save, and it is cleared only by a comparison that completes after power returns. A power-save interval also forces the lock flag high. That makes a large-gap comparison straight after the restart the only way to see suppression at the ports. The bench does exactly this: it checks that the flag stays high through the suppressed comparison and falls on the next one with the same gap. The lock confirmation count is reached with gap sweeps in both lead directions and both polarities. Deliberate bad gaps are inserted between good ones to show that the count restarts.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Comparison phase of the detector
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_FR_LEAD = 2'd1,
    PH_FP_LEAD = 2'd2,
    PH_BOTH    = 2'd3
  } ph_state_t;

endpackage

// File: rtl/pd_phase_fsm.sv
module pd_phase_fsm
  import pd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fr_in,
  input  logic             fp_in,
  output ph_state_t        state,
  output logic             done,
  output logic [CNT_W-1:0] err
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ph_state_t        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] cnt_inc;

  // Gap counter saturates at full scale
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CNT_ONE;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    done    = 1'b0;
    err     = '0;
    if (!enable) begin
      state_n = PH_IDLE;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE, PH_BOTH: begin
          if (fr_in && fp_in) begin
            state_n = PH_BOTH;
            done    = 1'b1;
            err     = '0;
            cnt_n   = '0;
          end else if (fr_in) begin
            state_n = PH_FR_LEAD;
            cnt_n   = CNT_ONE;
          end else if (fp_in) begin
            state_n = PH_FP_LEAD;
            cnt_n   = CNT_ONE;
          end else begin
            state_n = PH_IDLE;
            cnt_n   = '0;
          end
        end
        PH_FR_LEAD: begin
          if (fp_in) begin
            state_n = PH_BOTH;
            done    = 1'b1;
            err     = cnt_q;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        PH_FP_LEAD: begin
          if (fr_in) begin
            state_n = PH_BOTH;
            done    = 1'b1;
            err     = cnt_q;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        default: begin
          state_n = PH_IDLE;
          cnt_n   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pd_lock_det.sv
module pd_lock_det #(
  parameter int ERR_W       = 6,
  parameter int UNLOCK_CLKS = 3,
  parameter int LOCK_CLKS   = 2,
  parameter int CONFIRM     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             done,
  input  logic             suppress,
  input  logic [ERR_W-1:0] err,
  output logic             lock_q
);

  localparam int GOOD_W = $clog2(CONFIRM + 1);
  localparam logic [ERR_W-1:0]  UNLOCK_V = ERR_W'(UNLOCK_CLKS);
  localparam logic [ERR_W-1:0]  LOCK_V   = ERR_W'(LOCK_CLKS);
  localparam logic [GOOD_W-1:0] LAST_V   = GOOD_W'(CONFIRM - 1);
  localparam logic [GOOD_W-1:0] ONE_V    = GOOD_W'(1);

  logic              lock_n;
  logic [GOOD_W-1:0] good_q, good_n;
  logic              take;

  assign take = done && !suppress;

  always_comb begin
    lock_n = lock_q;
    good_n = good_q;
    if (!enable) begin
      lock_n = 1'b1;
      good_n = '0;
    end else if (take) begin
      if (err >= UNLOCK_V) begin
        lock_n = 1'b0;
        good_n = '0;
      end else if (err <= LOCK_V) begin
        if (good_q >= LAST_V) begin
          lock_n = 1'b1;
        end else begin
          good_n = good_q + ONE_V;
        end
      end else begin
        good_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else begin
      lock_q <= lock_n;
      good_q <= good_n;
    end
  end

endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage
  import pd_pkg::*;
(
  input  ph_state_t state,
  input  logic      pwr_on,
  input  logic      suppress,
  input  logic      pol_fc,
  input  logic      mon_sel,
  input  logic      lock_q,
  input  logic      fr_in,
  input  logic      fp_in,
  output logic      pump_up,
  output logic      pump_dn,
  output logic      pump_oe,
  output logic      lock_flag,
  output logic      mon_out
);

  logic lead_fr, lead_fp, active;

  always_comb begin
    lead_fr   = (state == PH_FR_LEAD) || (state == PH_BOTH);
    lead_fp   = (state == PH_FP_LEAD) || (state == PH_BOTH);
    active    = pwr_on && !suppress;
    pump_up   = active && (pol_fc ? lead_fr : lead_fp);
    pump_dn   = active && (pol_fc ? lead_fp : lead_fr);
    pump_oe   = pump_up || pump_dn;
    lock_flag = lock_q || !pwr_on;
    if (mon_sel) mon_out = pol_fc ? fr_in : fp_in;
    else         mon_out = lock_flag;
  end

endmodule

// File: rtl/pd_lockdet.sv
module pd_lockdet
  import pd_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int UNLOCK_CLKS = 3,
  parameter int LOCK_CLKS   = 2,
  parameter int CONFIRM     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_in,
  input  logic fp_in,
  input  logic pwr_on,
  input  logic pol_fc,
  input  logic mon_sel,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic lock_flag,
  output logic mon_out
);

  ph_state_t        state;
  logic             done;
  logic [CNT_W-1:0] err;
  logic             lock_q;
  logic             skip_q, skip_n;

  pd_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (pwr_on),
    .fr_in  (fr_in),
    .fp_in  (fp_in),
    .state  (state),
    .done   (done),
    .err    (err)
  );

  // Restart guard: armed in power save, released after the first
  // comparison (including its closing pulse) has gone by.
  always_comb begin
    skip_n = skip_q;
    if (!pwr_on)               skip_n = 1'b1;
    else if (state == PH_BOTH) skip_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= skip_n;
  end

  pd_lock_det #(
    .ERR_W       (CNT_W),
    .UNLOCK_CLKS (UNLOCK_CLKS),
    .LOCK_CLKS   (LOCK_CLKS),
    .CONFIRM     (CONFIRM)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (pwr_on),
    .done     (done),
    .suppress (skip_q),
    .err      (err),
    .lock_q   (lock_q)
  );

  pd_out_stage u_out (
    .state     (state),
    .pwr_on    (pwr_on),
    .suppress  (skip_q),
    .pol_fc    (pol_fc),
    .mon_sel   (mon_sel),
    .lock_q    (lock_q),
    .fr_in     (fr_in),
    .fp_in     (fp_in),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_oe   (pump_oe),
    .lock_flag (lock_flag),
    .mon_out   (mon_out)
  );

endmodule

// File: rtl/pd_lockdet_checker.sv
module pd_lockdet_checker (
  input logic clk,
  input logic rst_n,
  input logic fr_in,
  input logic fp_in,
  input logic pwr_on,
  input logic pol_fc,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_oe,
  input logic lock_flag
);

  // R9: power save silences the pump and holds the lock flag high
  a_r9_ps_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!pump_up && !pump_dn && !pump_oe && lock_flag));

  // R6: the closing pulse lasts one cycle unless a simultaneous pair follows
  a_r6_single_close: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn && !(fr_in && fp_in)) |=> !(pump_up && pump_dn));

  // R2: a lone rising up-drive under positive polarity follows an fr pulse
  a_r2_up_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && $past(pwr_on) && pol_fc && $stable(pol_fc) &&
     $rose(pump_up) && !pump_dn) |-> $past(fr_in));

  // R7: lock falls only as a comparison closes on a one-sided lead
  a_r7_unlock_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && $past(pwr_on) && $fell(lock_flag)) |->
      (pump_up && pump_dn && $past(pump_up != pump_dn)));

  // R8: lock rises only as a counted comparison closes
  a_r8_lock_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && $past(pwr_on) && $rose(lock_flag)) |-> (pump_up && pump_dn));

  // R12: a repeated leading pulse keeps the lead drive on
  a_r12_lead_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && pol_fc && pump_up && !pump_dn && fr_in && !fp_in) |=>
      (pump_up || !pwr_on || !pol_fc));

endmodule

bind pd_lockdet pd_lockdet_checker u_chk (.*);

// File: tb/pd_lockdet_test.sv
module pd_lockdet_test;

  localparam int CLK_NS = 8;

  logic clk, rst_n, fr_in, fp_in, pwr_on, pol_fc, mon_sel;
  logic pump_up, pump_dn, pump_oe, lock_flag, mon_out;

  int n_chk = 0;
  int n_fail = 0;
  bit lk_exp = 0;
  int gd_exp = 0;

  pd_lockdet uut (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in),
    .pwr_on(pwr_on), .pol_fc(pol_fc), .mon_sel(mon_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
    .lock_flag(lock_flag), .mon_out(mon_out)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one comparison: leader pulse at cycle 0, follower at cycle e,
  // optional repeat of the leader at cycle dup. Checks pump outputs per
  // cycle and the lock flag afterwards.
  task automatic run_cmp(input int e, input bit fr_first, input bit active,
                         input int dup, input string req);
    bit ok = 1;
    int act_v = 0;
    int exp_v = 0;
    bit hi_up = (fr_first == pol_fc);
    for (int cyc = 0; cyc <= e + 2; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        bit eu, ed;
        eu = 0; ed = 0;
        if (active) begin
          if (cyc <= e) begin eu = hi_up; ed = !hi_up; end
          else if (cyc == e + 1) begin eu = 1; ed = 1; end
        end
        if (pump_up !== eu || pump_dn !== ed || pump_oe !== (eu | ed)) begin
          if (ok) begin
            act_v = {pump_up, pump_dn, pump_oe};
            exp_v = {eu, ed, eu | ed};
          end
          ok = 0;
        end
      end
      fr_in = fr_first ? (cyc == 0 || cyc == dup) : (cyc == e);
      fp_in = fr_first ? (cyc == e) : (cyc == 0 || cyc == dup);
    end
    check(ok, req, act_v, exp_v);
    if (active && pwr_on) begin
      if (e >= 3) begin lk_exp = 0; gd_exp = 0; end
      else if (gd_exp == 2) lk_exp = 1;
      else gd_exp++;
    end
    check(lock_flag === lk_exp, "R7/R8 lock_flag", lock_flag, lk_exp);
    @(negedge clk);
    fr_in = 0; fp_in = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; fr_in = 0; fp_in = 0; pwr_on = 1; pol_fc = 1; mon_sel = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({pump_up, pump_dn, pump_oe, lock_flag} === 4'b0, "R1 during reset",
          {pump_up, pump_dn, pump_oe, lock_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    check({pump_up, pump_dn, pump_oe, lock_flag} === 4'b0, "R1 after reset",
          {pump_up, pump_dn, pump_oe, lock_flag}, 0);

    // R2 R3 R4 R5 R6 R7 R8: sweep of gaps, directions and polarities
    for (int f = 1; f >= 0; f--) begin
      pol_fc = f[0];
      for (int d = 1; d >= 0; d--) begin
        for (int e = 0; e <= 6; e++) begin
          string rq;
          if (e == 0) rq = "R5 simultaneous";
          else if (f == 1 && d == 1) rq = "R2 fr leads";
          else if (f == 1) rq = "R3 fp leads";
          else rq = "R4 swapped polarity";
          run_cmp(e, d[0], 1, -1, rq);
        end
      end
    end

    // R8: a bad gap restarts the confirmation count
    pol_fc = 1;
    run_cmp(1, 1, 1, -1, "R8 good 1");
    run_cmp(1, 0, 1, -1, "R8 good 2");
    run_cmp(4, 1, 1, -1, "R8 bad restarts");
    run_cmp(2, 0, 1, -1, "R8 good 1 again");
    run_cmp(0, 1, 1, -1, "R8 good 2 again");
    run_cmp(1, 1, 1, -1, "R8 third good locks");

    // R12: repeated leading pulse does not restart the lead
    run_cmp(4, 1, 1, 2, "R12 repeated fr");

    // R9: power save
    @(negedge clk);
    pwr_on = 0; lk_exp = 1; gd_exp = 0;
    #1;
    check(lock_flag === 1'b1 && pump_oe === 1'b0, "R9 ps outputs",
          {lock_flag, pump_oe}, 2);
    run_cmp(2, 1, 0, -1, "R9 pulses ignored");
    run_cmp(5, 0, 0, -1, "R9 pulses ignored fp");

    // R10: first comparison after power returns is suppressed
    @(negedge clk);
    pwr_on = 1;
    run_cmp(5, 1, 0, -1, "R10 suppressed");
    run_cmp(5, 1, 1, -1, "R10 next is live (R7)");

    // R11: monitor select
    @(negedge clk);
    mon_sel = 0; #1;
    check(mon_out === lock_flag, "R11 lock on mon", mon_out, lock_flag);
    mon_sel = 1; pol_fc = 1; fr_in = 1; fp_in = 0; #1;
    check(mon_out === 1'b1, "R11 fr on mon", mon_out, 1);
    pol_fc = 0; #1;
    check(mon_out === 1'b0, "R11 fp on mon low", mon_out, 0);
    fr_in = 0; fp_in = 1; #1;
    check(mon_out === 1'b1, "R11 fp on mon high", mon_out, 1);
    fp_in = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule